// File: doc/BRIEF.md
# Runahead Entry Gating Filter

This block sits beside the retirement stage of an out-of-order core. It decides whether the core may switch into runahead mode while a load that missed the second-level cache is stalling retirement. A grant needs three independent tests to agree. The non-overlap test requires the fetch distance since the last runahead period to exceed the length of that period. The stall-duration test requires the blocking miss to have waited long enough. The parallelism predictor, a small table of 2-bit saturating counters indexed by the load address, must expect further misses to be exposed.

The block also tracks its own runahead state. Runahead starts in the cycle after a grant and lasts until the triggering miss is reported serviced. On leaving runahead, the block stores the period length, restarts the fetch-distance count and trains the predictor entry that triggered the period.

Top module: `runahead_gate`

## Requirements
- R1: After reset `enterGrant` and `raActive` are low, the saved period length is 0, the fetch distance is at its maximum, the wait count is 0 and every predictor counter holds 2. A first qualifying miss is therefore granted as soon as the wait test passes.
- R2: A grant requires the fetch distance to be strictly greater than the saved period length. Equality blocks entry.
- R3: While `raActive` is low, the fetch distance adds `fetchCount` every cycle and saturates at 65535. It becomes 0 in the cycle after runahead ends and does not change while `raActive` is high.
- R4: The saved period length is the saturating (65535) sum of `retireCount` over every cycle with `raActive` high, including the exit cycle. It is latched when runahead ends.
- R5: The wait count adds 1 in each cycle with `missAtHead` high, saturates at 4095, and clears in any cycle with `missServiced` high. A grant requires the wait count, as registered at the start of the cycle, to be at least `waitThresh`.
- R6: The predictor entry is selected by `missPc[5:0]`. A grant is vetoed when that entry holds 0 or 1.
- R7: On runahead exit, the entry captured at grant is incremented when `extraMiss` was high in any active cycle, including the exit cycle. Otherwise it is decremented. The counter saturates at 0 and 3.
- R8: `enterGrant` is combinational and high only when `missAtHead` is high, `raActive` is low and R2, R5 and R6 all pass. It never stays high for two consecutive cycles.
- R9: `raActive` rises in the cycle after a grant. It stays high until a cycle in which `missServiced` is high, and falls in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchCount | input | 4 | Instructions fetched this cycle |
| retireCount | input | 4 | Instructions pseudo-retired this cycle |
| missAtHead | input | 1 | Oldest instruction is a load waiting on a cache miss |
| missPc | input | 32 | Address of that load |
| missServiced | input | 1 | Pulse: the blocking miss data returned |
| extraMiss | input | 1 | Pulse: another miss was generated this cycle |
| waitThresh | input | 12 | Minimum wait cycles before entry |
| enterGrant | output | 1 | Pulse: enter runahead now |
| raActive | output | 1 | Core is in runahead mode |

## Verification
Two events can land on the exit cycle of a runahead period: the last pseudo-retire count and a further miss pulse. Both must still count toward the saved length and the predictor training. The bench provokes this by asserting `retireCount` and `extraMiss` in the same cycle as `missServiced`. It then judges the outcome through later grant decisions, comparing each one with a behavioural reference model on every clock. Long saturation runs of fetch distance, saved length and wait count check the equal-length block and the threshold boundary the same way.

// File: rtl/runahead_gate_pkg.sv
package runahead_gate_pkg;
  typedef struct packed {
    logic countFetch;
    logic countRetire;
    logic enterNow;
    logic exitNow;
  } gateStrobes_t;
endpackage

// File: rtl/runahead_gate_ctrl.sv
module runahead_gate_ctrl
  import runahead_gate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         missAtHead,
  input  logic         missServiced,
  input  logic         overlapOk,
  input  logic         waitOk,
  input  logic         mlpOk,
  output gateStrobes_t strobes,
  output logic         grant,
  output logic         inRa
);
  always_comb begin
    grant               = missAtHead && !inRa && overlapOk && waitOk && mlpOk;
    strobes.countFetch  = !inRa;
    strobes.countRetire = inRa;
    strobes.enterNow    = grant;
    strobes.exitNow     = inRa && missServiced;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                inRa <= 1'b0;
    else if (strobes.exitNow) inRa <= 1'b0;
    else if (grant)           inRa <= 1'b1;
  end

  // R8
  no_double_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    grant |=> !grant);
  // R9
  enter_follows_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    grant |=> inRa);
  // R9
  exit_on_service_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inRa && missServiced) |=> !inRa);
endmodule

// File: rtl/runahead_gate_datapath.sv
module runahead_gate_datapath
  import runahead_gate_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int WAIT_W      = 12,
  parameter int FETCH_W     = 4,
  parameter int RET_W       = 4,
  parameter int PC_W        = 32,
  parameter int MLP_ENTRIES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobes_t      strobes,
  input  logic [FETCH_W-1:0] fetchCount,
  input  logic [RET_W-1:0]  retireCount,
  input  logic              missAtHead,
  input  logic              missServiced,
  input  logic              extraMiss,
  input  logic [PC_W-1:0]   missPc,
  input  logic [WAIT_W-1:0] waitThresh,
  output logic              overlapOk,
  output logic              waitOk,
  output logic              mlpOk
);
  localparam int IDX_W = $clog2(MLP_ENTRIES);
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [WAIT_W-1:0] WAIT_MAX = '1;

  logic [CNT_W-1:0]  fetchSince, retAcc, savedLen;
  logic [WAIT_W-1:0] waitCnt;
  logic [1:0]        mlpTable [MLP_ENTRIES];
  logic [IDX_W-1:0]  trigIdx, curIdx;
  logic              sawExtra;
  logic [CNT_W:0]    fetchSum, retSum;

  assign curIdx    = missPc[IDX_W-1:0];
  assign fetchSum  = {1'b0, fetchSince} + (CNT_W+1)'(fetchCount);
  assign retSum    = {1'b0, retAcc} + (CNT_W+1)'(retireCount);
  assign overlapOk = fetchSince > savedLen;
  assign waitOk    = waitCnt >= waitThresh;
  assign mlpOk     = mlpTable[curIdx][1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchSince <= CNT_MAX;
      retAcc     <= '0;
      savedLen   <= '0;
      waitCnt    <= '0;
      sawExtra   <= 1'b0;
      trigIdx    <= '0;
    end else begin
      if (strobes.exitNow)
        fetchSince <= '0;
      else if (strobes.countFetch)
        fetchSince <= fetchSum[CNT_W] ? CNT_MAX : fetchSum[CNT_W-1:0];

      if (strobes.enterNow) begin
        retAcc   <= '0;
        sawExtra <= 1'b0;
        trigIdx  <= curIdx;
      end else if (strobes.exitNow) begin
        savedLen <= retSum[CNT_W] ? CNT_MAX : retSum[CNT_W-1:0];
        retAcc   <= '0;
        sawExtra <= 1'b0;
      end else if (strobes.countRetire) begin
        retAcc   <= retSum[CNT_W] ? CNT_MAX : retSum[CNT_W-1:0];
        sawExtra <= sawExtra | extraMiss;
      end

      if (missServiced)
        waitCnt <= '0;
      else if (missAtHead && waitCnt != WAIT_MAX)
        waitCnt <= waitCnt + 1'b1;
    end
  end

  for (genvar e = 0; e < MLP_ENTRIES; e++) begin : g_mlp
    always_ff @(posedge clk) begin
      if (!rstN)
        mlpTable[e] <= 2'd2;
      else if (strobes.exitNow && trigIdx == IDX_W'(e)) begin
        if (sawExtra || extraMiss) begin
          if (mlpTable[e] != 2'd3) mlpTable[e] <= mlpTable[e] + 2'd1;
        end else begin
          if (mlpTable[e] != 2'd0) mlpTable[e] <= mlpTable[e] - 2'd1;
        end
      end
    end
  end

  // R3
  fetch_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.exitNow |=> fetchSince == '0);
  // R3
  fetch_no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fetchSince == CNT_MAX && strobes.countFetch && !strobes.exitNow) |=> fetchSince == CNT_MAX);
  // R5
  wait_no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (waitCnt == WAIT_MAX && missAtHead && !missServiced) |=> waitCnt == WAIT_MAX);
  // R4
  saved_len_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.exitNow |=> $stable(savedLen));
endmodule

// File: rtl/runahead_gate.sv
module runahead_gate
  import runahead_gate_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int WAIT_W      = 12,
  parameter int FETCH_W     = 4,
  parameter int RET_W       = 4,
  parameter int PC_W        = 32,
  parameter int MLP_ENTRIES = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [FETCH_W-1:0] fetchCount,
  input  logic [RET_W-1:0]   retireCount,
  input  logic               missAtHead,
  input  logic [PC_W-1:0]    missPc,
  input  logic               missServiced,
  input  logic               extraMiss,
  input  logic [WAIT_W-1:0]  waitThresh,
  output logic               enterGrant,
  output logic               raActive
);
  gateStrobes_t strobes;
  logic overlapOk, waitOk, mlpOk;

  runahead_gate_ctrl u_ctrl (
    .clk, .rstN, .missAtHead, .missServiced,
    .overlapOk, .waitOk, .mlpOk,
    .strobes, .grant(enterGrant), .inRa(raActive)
  );

  runahead_gate_datapath #(
    .CNT_W(CNT_W), .WAIT_W(WAIT_W), .FETCH_W(FETCH_W), .RET_W(RET_W),
    .PC_W(PC_W), .MLP_ENTRIES(MLP_ENTRIES)
  ) u_dp (
    .clk, .rstN, .strobes, .fetchCount, .retireCount, .missAtHead,
    .missServiced, .extraMiss, .missPc, .waitThresh,
    .overlapOk, .waitOk, .mlpOk
  );

  // R8
  grant_needs_head_chk: assert property (@(posedge clk) disable iff (!rstN)
    enterGrant |-> missAtHead && !raActive);
endmodule

// File: tb/tb_runahead_gate.sv
module tb_runahead_gate;
  logic clk = 0, rstN = 0;
  logic [3:0] fetchCount = 0, retireCount = 0;
  logic missAtHead = 0, missServiced = 0, extraMiss = 0;
  logic [31:0] missPc = 0;
  logic [11:0] waitThresh = 0;
  logic enterGrant, raActive;

  always #5 clk = ~clk;

  runahead_gate dut (.*);

  int errors = 0, checks = 0, cycles = 0;
  string curReq = "R1";
  int mI, mN, mRsum, mW, mTrig, grants;
  bit mRa, mSaw;
  int mlp [64];

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int sat(int v, int mx);
    return (v > mx) ? mx : v;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int fc, int rc, bit head, int pc, bit svc, bit ex);
    bit eg;
    fetchCount = 4'(fc); retireCount = 4'(rc); missAtHead = head;
    missPc = 32'(pc); missServiced = svc; extraMiss = ex;
    #2;
    eg = head && !mRa && (mI > mN) && (mW >= int'(waitThresh)) && (mlp[pc % 64] >= 2);
    chk(curReq, int'(enterGrant), int'(eg));
    chk("R9", int'(raActive), int'(mRa));
    if (eg) grants++;
    @(posedge clk);
    if (!mRa) mI = sat(mI + fc, 65535);
    if (mRa) begin
      if (svc) begin
        mN = sat(mRsum + rc, 65535); mRsum = 0; mI = 0; mRa = 0;
        if (mSaw || ex) mlp[mTrig] = sat(mlp[mTrig] + 1, 3);
        else if (mlp[mTrig] > 0) mlp[mTrig]--;
        mSaw = 0;
      end else begin
        mRsum = sat(mRsum + rc, 65535); mSaw = mSaw | ex;
      end
    end
    if (eg) begin mRa = 1; mTrig = pc % 64; mSaw = 0; mRsum = 0; end
    if (svc) mW = 0; else if (head) mW = sat(mW + 1, 4095);
    @(negedge clk);
  endtask

  // one runahead period on pc: enter, retire rc for len cycles, exit
  task automatic period(int pc, int len, int rc, bit exMid, bit exLast);
    for (int k = 0; k < len; k++) cyc(0, rc, 1, pc, 0, exMid && k == 1);
    cyc(0, rc, 1, pc, 1, exLast);
  endtask

  initial begin
    mI = 65535; mN = 0; mRsum = 0; mW = 0; mTrig = 0; mRa = 0; mSaw = 0; grants = 0;
    foreach (mlp[k]) mlp[k] = 2;
    repeat (3) @(negedge clk);
    rstN = 1;
    #2;
    chk("R1", int'(enterGrant), 0);
    chk("R1", int'(raActive), 0);

    // R1: first miss granted at once
    curReq = "R1";
    cyc(0, 0, 1, 5, 0, 0);
    chk("R1", grants, 1);
    // R4/R7: period of 4 cycles retiring 3, no extra miss -> n=15, pc5 ctr 1
    curReq = "R4";
    period(5, 4, 3, 0, 0);
    // R6: pc 5 vetoed even with plenty of fetch
    curReq = "R6";
    for (int k = 0; k < 3; k++) cyc(15, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 5, 0, 0);
    cyc(0, 0, 1, 5, 1, 0);
    chk("R6", grants, 1);
    // R2: i == n blocks; i = 45 vs n = 15 -> grant on pc 6 after reset of i
    curReq = "R2";
    cyc(0, 0, 1, 6, 0, 0);             // i=45 > 15, grant
    period(6, 2, 5, 0, 0);             // n = 15
    cyc(15, 0, 0, 0, 0, 0);            // i = 15
    cyc(0, 0, 1, 6, 0, 0);             // equal: blocked (pc6 ctr 1 too)
    cyc(0, 0, 1, 7, 0, 0);             // pc7 ctr 2, but i == n: blocked
    chk("R2", grants, 2);
    cyc(1, 0, 1, 7, 0, 0);             // still blocked, i -> 16
    cyc(0, 0, 1, 7, 0, 0);             // granted
    chk("R2", grants, 3);
    // R7: extra miss only on exit cycle trains up pc7 -> 3
    curReq = "R7";
    period(7, 2, 0, 0, 1);             // n = 0
    cyc(1, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 7, 0, 0);
    period(7, 3, 1, 1, 0);             // mid-period extra: stays 3
    cyc(5, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 7, 0, 0);
    period(7, 1, 0, 0, 0);             // no extra: 3 -> 2, still predicts
    cyc(1, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 7, 0, 0);
    chk("R7", grants, 6);
    period(7, 1, 0, 0, 0);             // 2 -> 1
    cyc(1, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 7, 1, 0);
    // R5: threshold 5 on pc 8
    curReq = "R5";
    waitThresh = 5;
    for (int k = 0; k < 7; k++) cyc(0, 0, 1, 8, 0, 0);
    chk("R5", grants, 7);
    period(8, 1, 0, 0, 1);
    // R5: wait saturation with threshold 4095
    waitThresh = 12'd4095;
    cyc(1, 0, 0, 0, 0, 0);
    for (int k = 0; k < 4100; k++) cyc(0, 0, 1, 8, 0, 0);
    chk("R5", grants, 8);
    period(8, 1, 0, 0, 1);
    waitThresh = 0;
    // R3/R4: saturate saved length, then fetch distance can never exceed it
    curReq = "R3";
    cyc(1, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 9, 0, 0);
    period(9, 4400, 15, 1, 0);         // n = 65535
    for (int k = 0; k < 4400; k++) cyc(15, 0, 0, 0, 0, 0);
    curReq = "R4";
    cyc(15, 0, 1, 9, 0, 0);
    cyc(0, 0, 1, 10, 0, 0);
    chk("R4", grants, 9);
    cyc(0, 0, 0, 0, 1, 0);
    curReq = "R8";
    for (int k = 0; k < 4; k++) cyc(0, 0, 1, 11, 0, 0);
    chk("R8", grants, 9);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule